// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose I/O lines. Each line has an output value and an output enable, which drive a tristate pad buffer outside the block. Each line also has an input path that passes through a synchroniser, so software can read the pad level. Software reaches the bank through a small word-wide register port with two windows. The data window holds pin readback and the write-one-to-set and write-one-to-clear controls for output value and direction. The interrupt window holds trigger configuration, mask, acknowledge and the pending view.

Each line can raise an interrupt on a high level, a low level, a rising edge, a falling edge or either edge. The type is encoded per line across three configuration vectors. Edge events are held in a latch until software acknowledges them. Level conditions follow the synchronised input. A mask bit of 1 hides a line. The bank combines all unmasked conditions into one active-high level request for a parent interrupt controller.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all lines are inputs (`pad_oe` = 0) and all outputs are low. The mask register (irq window 0xA) reads all ones. Edge-mode, both-edge and polarity registers read 0. Pending (0xC) reads 0 and `irq_o` is 0.
- R2: In the data window, writing 1s at offset 0x0 sets those output bits and writing 1s at 0x4 clears them. Bits written as 0 keep their value. A read at 0x4 returns the output-value vector.
- R3: In the data window, writing 1s at 0x2 makes those lines outputs and writing 1s at 0x6 makes them inputs. Zero bits keep their value. Reads at 0x2 and 0x6 return the output-enable vector, where 1 means output.
- R4: A read at data offset 0x0 returns the pad levels after a two-flop synchroniser. A pad change becomes visible after the second rising clock edge.
- R5: A line with (edge, both, polarity) = (0,0,1) in irq offsets 0x4, 0x6 and 0x8 is pending while its synchronised input is 1 and it is unmasked.
- R6: A line configured (0,0,0) is pending while its synchronised input is 0 and it is unmasked.
- R7: A line configured (1,0,1) latches an event on a 0-to-1 transition of the synchronised input. The event is pending from the third clock edge after the pad change, and it stays pending after the input returns low.
- R8: A line configured (1,0,0) latches an event only on a 1-to-0 transition.
- R9: A line with edge = 1 and both = 1 latches an event on either transition, whatever its polarity bit holds.
- R10: A mask bit of 1 (irq offset 0xA) removes the line from pending and from `irq_o`. A latched event survives masking and reappears when the line is unmasked.
- R11: Writing 1s to irq offset 0x0 clears those lines' latched events, and 0 bits leave events alone. If a new event arrives in the same cycle as the acknowledge, the new event stays latched.
- R12: `irq_o` is high exactly when the pending register is non-zero.
- R13: The configuration registers read back what was written. Irq offset 0x0 reads the raw latched events, before masking. Any other offset reads 0, and writes to other offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_win | input | 1 | Window select: 0 data, 1 interrupt |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 16 | Write data, one bit per line |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| pad_in | input | 16 | Pad levels as seen at the pins |
| pad_out | output | 16 | Output values to the pad buffers |
| pad_oe | output | 16 | Output enables to the pad buffers (1 = drive) |
| irq_o | output | 1 | Active-high level request to the parent controller |

## Verification
The bench builds the bank with its default 16 lines and a two-stage synchroniser. Every line can therefore take a different trigger type at the same time: level-high, level-low, rising, falling and either-edge each sit on a line of their own. This lets the bench show that the modes do not disturb one another. The two-stage setting fixes the latency the reference model assumes: two edges for readback and level pending, three for an edge event. The reference model therefore checks each output against those exact cycles during both the directed and the random phases.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    typedef enum logic {WIN_DATA = 1'b0, WIN_IRQ = 1'b1} win_e;

    localparam logic [3:0] D_PIN_SET  = 4'h0;
    localparam logic [3:0] D_OE_SET   = 4'h2;
    localparam logic [3:0] D_OUT_CLR  = 4'h4;
    localparam logic [3:0] D_OE_CLR   = 4'h6;

    localparam logic [3:0] I_ACK      = 4'h0;
    localparam logic [3:0] I_EDGE     = 4'h4;
    localparam logic [3:0] I_BOTH     = 4'h6;
    localparam logic [3:0] I_POL      = 4'h8;
    localparam logic [3:0] I_MASK     = 4'hA;
    localparam logic [3:0] I_PEND     = 4'hC;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_trig.sv
module gpio_bank_trig #(
    parameter int W = 16
) (
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] edge_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] lat_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] hit_o,
    output logic [W-1:0] pend_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic rise, fall, sel, lvl;
        assign rise = sync_i[g] & ~prev_i[g];
        assign fall = ~sync_i[g] & prev_i[g];
        // either transition when both-edge is set, else the one the polarity names
        assign sel  = both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall);
        assign hit_o[g] = edge_i[g] & sel;
        assign lvl  = (sync_i[g] == pol_i[g]);
        assign pend_o[g] = ~mask_i[g] & (edge_i[g] ? lat_i[g] : lvl);
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int W          = 16,
    parameter int ADDR_W     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic              irq_o
);
    localparam logic [W-1:0] ALL_MASKED = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] out;
        logic [W-1:0] oe;
        logic [W-1:0] prev;
        logic [W-1:0] lat;
        logic [W-1:0] edge_m;
        logic [W-1:0] both;
        logic [W-1:0] pol;
        logic [W-1:0] mask;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] sync_w, hit_w, pend_w, ack_w;
    logic [3:0]   off_w;
    logic         wr_data, wr_irq;

    gpio_bank_sync #(.W(W), .STAGES(SYNC_DEPTH)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (sync_w)
    );

    gpio_bank_trig #(.W(W)) trig_i (
        .sync_i (sync_w),
        .prev_i (st_q.prev),
        .edge_i (st_q.edge_m),
        .both_i (st_q.both),
        .pol_i  (st_q.pol),
        .lat_i  (st_q.lat),
        .mask_i (st_q.mask),
        .hit_o  (hit_w),
        .pend_o (pend_w)
    );

    assign off_w   = 4'(bus_addr);
    assign wr_data = bus_we && (bus_win == WIN_DATA);
    assign wr_irq  = bus_we && (bus_win == WIN_IRQ);
    assign ack_w   = (wr_irq && off_w == I_ACK) ? bus_wdata : '0;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_w;
        // a fresh event outranks an acknowledge in the same cycle
        st_d.lat  = (st_q.lat & ~ack_w) | hit_w;
        if (wr_data) begin
            unique case (off_w)
                D_PIN_SET: st_d.out = st_q.out | bus_wdata;
                D_OUT_CLR: st_d.out = st_q.out & ~bus_wdata;
                D_OE_SET:  st_d.oe  = st_q.oe | bus_wdata;
                D_OE_CLR:  st_d.oe  = st_q.oe & ~bus_wdata;
                default: ;
            endcase
        end
        if (wr_irq) begin
            unique case (off_w)
                I_EDGE: st_d.edge_m = bus_wdata;
                I_BOTH: st_d.both   = bus_wdata;
                I_POL:  st_d.pol    = bus_wdata;
                I_MASK: st_d.mask   = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= ALL_MASKED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_win == WIN_DATA) begin
            unique case (off_w)
                D_PIN_SET:          bus_rdata = sync_w;
                D_OE_SET, D_OE_CLR: bus_rdata = st_q.oe;
                D_OUT_CLR:          bus_rdata = st_q.out;
                default: ;
            endcase
        end else begin
            unique case (off_w)
                I_ACK:  bus_rdata = st_q.lat;
                I_EDGE: bus_rdata = st_q.edge_m;
                I_BOTH: bus_rdata = st_q.both;
                I_POL:  bus_rdata = st_q.pol;
                I_MASK: bus_rdata = st_q.mask;
                I_PEND: bus_rdata = pend_w;
                default: ;
            endcase
        end
    end

    assign pad_out = st_q.out;
    assign pad_oe  = st_q.oe;
    assign irq_o   = |pend_w;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int W      = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_win,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic              irq_o,
    input logic [W-1:0]      mask_i
);
    logic dwr;
    assign dwr = bus_we && !bus_win;

    AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && bus_addr == 4'h0) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && bus_addr == 4'h4) |=> ((pad_out & $past(bus_wdata)) == '0)); // R2
    AST_OE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && bus_addr == 4'h2) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata))); // R3
    AST_OE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && bus_addr == 4'h6) |=> ((pad_oe & $past(bus_wdata)) == '0)); // R3
    AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dwr |=> ($stable(pad_out) && $stable(pad_oe))); // R2
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_i) |-> !irq_o); // R10
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_o     (irq_o),
    .mask_i    (st_q.mask)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_win = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] ext = '0;
    logic [15:0] pad_in;
    logic [15:0] pad_out, pad_oe;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // pad: driven lines read back their own output, others follow the outside world
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] hist[$];   // [0] newest sample, [1] synchronised, [2] one older
    logic [15:0] m_out, m_oe, m_lat, m_edge, m_both, m_pol, m_mask;

    function automatic logic [15:0] m_pend();
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            if (m_mask[i]) r[i] = 1'b0;
            else if (m_edge[i]) r[i] = m_lat[i];
            else r[i] = (hist[1][i] == m_pol[i]);
        end
        return r;
    endfunction

    function automatic logic [15:0] m_read(logic win, logic [3:0] a);
        if (!win) begin
            case (a)
                4'h0: return hist[1];
                4'h2, 4'h6: return m_oe;
                4'h4: return m_out;
                default: return 16'h0;
            endcase
        end
        case (a)
            4'h0: return m_lat;
            4'h4: return m_edge;
            4'h6: return m_both;
            4'h8: return m_pol;
            4'hA: return m_mask;
            4'hC: return m_pend();
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{16'h0, 16'h0, 16'h0};
            m_out = 0; m_oe = 0; m_lat = 0; m_edge = 0; m_both = 0; m_pol = 0;
            m_mask = 16'hFFFF;
        end else begin
            logic [15:0] ev;
            for (int i = 0; i < 16; i++) begin
                bit up, dn;
                up = hist[1][i] && !hist[2][i];
                dn = !hist[1][i] && hist[2][i];
                ev[i] = m_edge[i] && (m_both[i] ? (up || dn) : (m_pol[i] ? up : dn));
            end
            if (bus_we && bus_win && bus_addr == 4'h0) m_lat = m_lat & ~bus_wdata;
            m_lat = m_lat | ev;
            if (bus_we && !bus_win) begin
                case (bus_addr)
                    4'h0: m_out = m_out | bus_wdata;
                    4'h4: m_out = m_out & ~bus_wdata;
                    4'h2: m_oe  = m_oe | bus_wdata;
                    4'h6: m_oe  = m_oe & ~bus_wdata;
                    default: ;
                endcase
            end
            if (bus_we && bus_win) begin
                case (bus_addr)
                    4'h4: m_edge = bus_wdata;
                    4'h6: m_both = bus_wdata;
                    4'h8: m_pol  = bus_wdata;
                    4'hA: m_mask = bus_wdata;
                    default: ;
                endcase
            end
            hist.push_front(pad_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2 pad_out", pad_out, m_out);
            chk("R3 pad_oe", pad_oe, m_oe);
            chk("R12 irq_o", {15'h0, irq_o}, {15'h0, (m_pend() != 16'h0)});
            chk("R13 bus_rdata", bus_rdata, m_read(bus_win, bus_addr));
        end
    end

    task automatic wr(logic win, logic [3:0] a, logic [15:0] d);
        @(negedge clk); #1;
        bus_win = win; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(string tag, logic win, logic [3:0] a, logic [15:0] exp);
        @(negedge clk); #1;
        bus_we = 1'b0; bus_win = win; bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        rd("R1 mask", 1'b1, 4'hA, 16'hFFFF);
        rd("R1 pending", 1'b1, 4'hC, 16'h0000);
        rd("R1 edge", 1'b1, 4'h4, 16'h0000);
        chk("R1 oe", pad_oe, 16'h0);
        chk("R1 out", pad_out, 16'h0);
        chk("R1 irq", {15'h0, irq_o}, 16'h0);
        // R2 output set/clear
        wr(1'b0, 4'h0, 16'h00F3);
        rd("R2 set", 1'b0, 4'h4, 16'h00F3);
        wr(1'b0, 4'h4, 16'h0003);
        rd("R2 clear", 1'b0, 4'h4, 16'h00F0);
        // R3 direction set/clear
        wr(1'b0, 4'h2, 16'h000F);
        wr(1'b0, 4'h6, 16'h0005);
        rd("R3 oe via clr", 1'b0, 4'h6, 16'h000A);
        rd("R3 oe via set", 1'b0, 4'h2, 16'h000A);
        // R4 readback
        ext = 16'h5A00;
        idle(3);
        rd("R4 pins", 1'b0, 4'h0, 16'h5A00);
        wr(1'b0, 4'h6, 16'hFFFF);
        wr(1'b0, 4'h4, 16'hFFFF);
        ext = 16'h0000;
        idle(3);
        // line0 high, line1 low, line2 rise, line3 fall, line4 either
        wr(1'b1, 4'h4, 16'h001C);
        wr(1'b1, 4'h6, 16'h0010);
        wr(1'b1, 4'h8, 16'h0015);
        wr(1'b1, 4'hA, 16'hFFE0);
        rd("R6 low level", 1'b1, 4'hC, 16'h0002);
        chk("R12 irq high", {15'h0, irq_o}, 16'h1);
        ext[0] = 1'b1; idle(3);
        rd("R5 high level", 1'b1, 4'hC, 16'h0003);
        ext[2] = 1'b1; idle(4);
        rd("R7 rise", 1'b1, 4'hC, 16'h0007);
        ext[2] = 1'b0; idle(4);
        rd("R7 held", 1'b1, 4'hC, 16'h0007);
        ext[3] = 1'b1; idle(4);
        rd("R8 no rise event", 1'b1, 4'hC, 16'h0007);
        ext[3] = 1'b0; idle(4);
        rd("R8 fall", 1'b1, 4'hC, 16'h000F);
        ext[4] = 1'b1; idle(4);
        rd("R9 rise", 1'b1, 4'hC, 16'h001F);
        wr(1'b1, 4'h0, 16'h0010);
        rd("R11 ack", 1'b1, 4'hC, 16'h000F);
        ext[4] = 1'b0; idle(4);
        rd("R9 fall", 1'b1, 4'hC, 16'h001F);
        wr(1'b1, 4'h0, 16'h0000);
        rd("R11 zero ack", 1'b1, 4'hC, 16'h001F);
        wr(1'b1, 4'h0, 16'h0004);
        rd("R11 ack line2", 1'b1, 4'hC, 16'h001B);
        wr(1'b1, 4'hA, 16'hFFE8);
        rd("R10 masked", 1'b1, 4'hC, 16'h0013);
        rd("R10 raw kept", 1'b1, 4'h0, 16'h0018);
        wr(1'b1, 4'hA, 16'hFFE0);
        rd("R10 unmasked", 1'b1, 4'hC, 16'h001B);
        wr(1'b1, 4'hA, 16'hFFFF);
        rd("R12 all masked", 1'b1, 4'hC, 16'h0000);
        chk("R12 irq low", {15'h0, irq_o}, 16'h0);
        rd("R13 unused", 1'b0, 4'h8, 16'h0000);
        wr(1'b1, 4'hE, 16'hFFFF);
        rd("R13 mask kept", 1'b1, 4'hA, 16'hFFFF);
        rd("R13 edge cfg", 1'b1, 4'h4, 16'h001C);
        // random phase: model comparison every clock
        for (int n = 0; n < 600; n++) begin
            @(negedge clk); #1;
            ext      = 16'($urandom);
            bus_win  = 1'($urandom);
            bus_addr = 4'($urandom_range(0, 7) * 2);
            bus_wdata = 16'($urandom);
            bus_we   = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk); #1 bus_we = 1'b0;
        idle(4);
        finish_run();
    end
endmodule